// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block decides, every cycle, whether the instruction in the decode stage of a five-stage in-order pipeline may move on to execute. It compares the register sources of the decoding instruction with the destinations of the two older instructions still in flight, one in execute and one in memory access. When a needed value cannot yet be obtained, it freezes the program counter and the fetch/decode pipeline register and asks for a bubble in the decode/execute register. It handles no branches and drives no forwarding multiplexers.

The block is purely combinational. Its decisions take effect at the next clock edge through the pipeline registers that it enables. A build-time parameter picks the operand-delivery scheme of the surrounding core. With full forwarding, only a load result that an execute-stage consumer needs right away costs a cycle. Without forwarding, any consumer must wait until its producer reaches write-back, where the register file writes in the first half of the cycle and reads in the second.

Top module: `hazard_stall_unit`

## Requirements
- R1: With `FORWARD_EN=1`, a load in execute (`exLoad=1`, `exWrites=1`, `exDest`≠0) whose destination equals a used first source (`idUseA=1`), or a used second source that is not store data (`idUseB=1`, `idBIsStoreData=0`), stalls decode for exactly one cycle. A store whose base register is the loaded register counts as such a consumer.
- R2: With `FORWARD_EN=1`, a load in execute followed directly by a store whose data register (`idUseB=1`, `idBIsStoreData=1`) is the loaded register, and whose base register does not match, causes no stall.
- R3: With `FORWARD_EN=1`, a non-load producer in execute, or any producer in memory access, never causes a stall.
- R4: With `FORWARD_EN=0`, a producer in execute or memory access whose destination matches any used source, including store data, stalls. A consumer directly behind its producer therefore stalls for two consecutive cycles.
- R5: With `FORWARD_EN=0`, a consumer two instructions behind its producer stalls one cycle, and one three instructions behind stalls none.
- R6: A stage whose destination is register 0, or whose write flag is low, never causes a stall.
- R7: A source field whose use flag is low never causes a stall, whatever its value.
- R8: When no stall is needed, `pcWrite=1`, `ifIdWrite=1` and `idExBubble=0`. During a stall, `pcWrite=0`, `ifIdWrite=0` and `idExBubble=1`, all three changing together.
- R9: The outputs follow the inputs within the same cycle. A held decode instruction is re-evaluated each cycle until its operands can be delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idSrcA | input | REG_W | First source register of the decoding instruction |
| idUseA | input | 1 | First source is read |
| idSrcB | input | REG_W | Second source register of the decoding instruction |
| idUseB | input | 1 | Second source is read |
| idBIsStoreData | input | 1 | Second source is only needed as store data in memory access |
| exDest | input | REG_W | Destination register of the instruction in execute |
| exWrites | input | 1 | Instruction in execute writes a register |
| exLoad | input | 1 | Instruction in execute is a load |
| memDest | input | REG_W | Destination register of the instruction in memory access |
| memWrites | input | 1 | Instruction in memory access writes a register |
| memLoad | input | 1 | Instruction in memory access is a load |
| pcWrite | output | 1 | Program counter update enable |
| ifIdWrite | output | 1 | Fetch/decode register update enable |
| idExBubble | output | 1 | Clear the control fields entering execute |

## Verification
Both in-flight stages can match the decoding instruction in the same cycle. This is provoked with two back-to-back loads followed by an instruction that reads both results. With forwarding, only the execute-stage load may hold decode, and for one cycle. Without forwarding, the memory-stage match and the execute-stage match together must produce exactly two stall cycles. A behavioural pipeline in the bench works out the expected decision from the distance rules on every clock, for both parameter settings side by side. It also compares the stall total of each short program with a count worked out by hand.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Stage index inside the in-flight arrays; 0 is the stage right after decode.
  localparam int STG_EX  = 0;
  localparam int STG_MEM = 1;

  // Strobes from the stall policy toward the pipeline enables.
  typedef struct packed {
    logic freeze;   // hold program counter and fetch/decode register
    logic bubble;   // clear control fields entering execute
  } stall_strobe_t;
endpackage

// File: rtl/hzd_match_dp.sv
module hzd_match_dp #(
  parameter int REG_W   = 5,
  parameter int NUM_STG = 2
) (
  input  logic [REG_W-1:0]              srcA,
  input  logic                          useA,
  input  logic [REG_W-1:0]              srcB,
  input  logic                          useB,
  input  logic                          bIsData,
  input  logic [NUM_STG-1:0][REG_W-1:0] stgDest,
  input  logic [NUM_STG-1:0]            stgWrites,
  output logic [NUM_STG-1:0]            execHit,
  output logic [NUM_STG-1:0]            dataHit
);
  for (genvar s = 0; s < NUM_STG; s++) begin : g_stage
    logic live;
    logic matchA;
    logic matchB;

    // R6: register 0 and non-writing stages are dead producers
    assign live   = stgWrites[s] && (stgDest[s] != '0);
    // R7: a source only counts when it is actually read
    assign matchA = useA && (srcA == stgDest[s]);
    assign matchB = useB && (srcB == stgDest[s]);

    assign execHit[s] = live && (matchA || (matchB && !bIsData));
    assign dataHit[s] = live && matchB && bIsData;

    always_comb begin
      p_zero_dest_silent_r6: assert (!((execHit[s] || dataHit[s]) && (stgDest[s] == '0)))
        else $error("stage %0d hit on register zero", s);
      p_data_hit_needs_store_r2: assert (!(dataHit[s] && !(useB && bIsData)))
        else $error("stage %0d data hit without store data source", s);
    end
  end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
  import hzd_pkg::*;
#(
  parameter bit FORWARD_EN = 1'b1,
  parameter int NUM_STG    = 2
) (
  input  logic [NUM_STG-1:0] execHit,
  input  logic [NUM_STG-1:0] dataHit,
  input  logic [NUM_STG-1:0] stgLoad,
  output stall_strobe_t      strb
);
  logic [NUM_STG-1:0] execReady;
  logic [NUM_STG-1:0] dataReady;
  logic [NUM_STG-1:0] stallReq;

  // Readiness of a producer's value for a consumer, per stage and per use point.
  for (genvar s = 0; s < NUM_STG; s++) begin : g_ready
    if (FORWARD_EN) begin : g_fwd
      // R1/R3: every result reaches execute in time except a load one stage ahead
      assign execReady[s] = !(stgLoad[s] && (s == STG_EX));
      // R2: store data is consumed in memory access, a load result can meet it there
      assign dataReady[s] = 1'b1;
    end else begin : g_nofwd
      // R4/R5: nothing is bypassed; wait until the producer has reached write-back
      assign execReady[s] = 1'b0 & stgLoad[s];
      assign dataReady[s] = 1'b0;
    end
    assign stallReq[s] = (execHit[s] && !execReady[s]) || (dataHit[s] && !dataReady[s]);
  end

  always_comb begin
    strb.freeze = |stallReq;
    strb.bubble = |stallReq;
  end

  always_comb begin
    p_stall_has_cause_r9: assert (!(strb.bubble && !(|execHit || |dataHit)))
      else $error("stall without any register match");
    if (FORWARD_EN) begin
      p_fwd_only_load_r1: assert (!(strb.bubble && !(stgLoad[STG_EX] && execHit[STG_EX])))
        else $error("forwarding stall without execute-stage load consumer");
    end
  end
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hzd_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter bit FORWARD_EN = 1'b1
) (
  input  logic [REG_W-1:0] idSrcA,
  input  logic             idUseA,
  input  logic [REG_W-1:0] idSrcB,
  input  logic             idUseB,
  input  logic             idBIsStoreData,
  input  logic [REG_W-1:0] exDest,
  input  logic             exWrites,
  input  logic             exLoad,
  input  logic [REG_W-1:0] memDest,
  input  logic             memWrites,
  input  logic             memLoad,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             idExBubble
);
  localparam int NUM_STG = 2;

  logic [NUM_STG-1:0][REG_W-1:0] stgDest;
  logic [NUM_STG-1:0]            stgWrites;
  logic [NUM_STG-1:0]            stgLoad;
  logic [NUM_STG-1:0]            execHit;
  logic [NUM_STG-1:0]            dataHit;
  stall_strobe_t                 strb;

  always_comb begin
    stgDest[STG_EX]    = exDest;
    stgDest[STG_MEM]   = memDest;
    stgWrites[STG_EX]  = exWrites;
    stgWrites[STG_MEM] = memWrites;
    stgLoad[STG_EX]    = exLoad;
    stgLoad[STG_MEM]   = memLoad;
  end

  hzd_match_dp #(.REG_W(REG_W), .NUM_STG(NUM_STG)) matchDp (
    .srcA     (idSrcA),
    .useA     (idUseA),
    .srcB     (idSrcB),
    .useB     (idUseB),
    .bIsData  (idBIsStoreData),
    .stgDest  (stgDest),
    .stgWrites(stgWrites),
    .execHit  (execHit),
    .dataHit  (dataHit)
  );

  hzd_stall_ctl #(.FORWARD_EN(FORWARD_EN), .NUM_STG(NUM_STG)) stallCtl (
    .execHit(execHit),
    .dataHit(dataHit),
    .stgLoad(stgLoad),
    .strb   (strb)
  );

  assign pcWrite    = !strb.freeze;
  assign ifIdWrite  = !strb.freeze;
  assign idExBubble = strb.bubble;

  always_comb begin
    p_enables_move_together_r8: assert ((pcWrite == ifIdWrite) && (idExBubble == !pcWrite))
      else $error("enables and bubble disagree");
    p_no_writer_no_stall_r6: assert (!(idExBubble && !exWrites && !memWrites))
      else $error("stall with no writing producer");
  end
endmodule

// File: tb/hazard_stall_unit_test.sv
module hazard_stall_unit_test;
  typedef struct packed {
    logic [4:0] dst;
    logic       wr;
    logic       ld;
    logic [4:0] a;
    logic       ua;
    logic [4:0] b;
    logic       ub;
    logic       bd;
  } ins_t;

  localparam ins_t NOP = '0;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 8 ns period

  ins_t idS[2];
  ins_t exS[2];
  ins_t memS[2];
  int   pcI[2];
  ins_t prog[16];
  int   progLen;
  int   vectors = 0;
  int   miscompares = 0;
  logic [1:0] pcW;
  logic [1:0] ifW;
  logic [1:0] bub;

  hazard_stall_unit #(.REG_W(5), .FORWARD_EN(1'b1)) uut (
    .idSrcA(idS[0].a), .idUseA(idS[0].ua), .idSrcB(idS[0].b), .idUseB(idS[0].ub),
    .idBIsStoreData(idS[0].bd),
    .exDest(exS[0].dst), .exWrites(exS[0].wr), .exLoad(exS[0].ld),
    .memDest(memS[0].dst), .memWrites(memS[0].wr), .memLoad(memS[0].ld),
    .pcWrite(pcW[0]), .ifIdWrite(ifW[0]), .idExBubble(bub[0])
  );

  hazard_stall_unit #(.REG_W(5), .FORWARD_EN(1'b0)) uutNoFwd (
    .idSrcA(idS[1].a), .idUseA(idS[1].ua), .idSrcB(idS[1].b), .idUseB(idS[1].ub),
    .idBIsStoreData(idS[1].bd),
    .exDest(exS[1].dst), .exWrites(exS[1].wr), .exLoad(exS[1].ld),
    .memDest(memS[1].dst), .memWrites(memS[1].wr), .memLoad(memS[1].ld),
    .pcWrite(pcW[1]), .ifIdWrite(ifW[1]), .idExBubble(bub[1])
  );

  function automatic ins_t mk(int dst, bit wr, bit ld, int a, bit ua, int b, bit ub, bit bd);
    ins_t r;
    r.dst = dst[4:0]; r.wr = wr; r.ld = ld;
    r.a = a[4:0]; r.ua = ua; r.b = b[4:0]; r.ub = ub; r.bd = bd;
    return r;
  endfunction

  // Distance rules: producer at distance 1 sits in execute, distance 2 in memory access.
  function automatic logic refStall(bit fwd, ins_t d, ins_t e, ins_t m);
    logic s = 1'b0;
    ins_t p;
    logic aN;
    logic bN;
    for (int k = 1; k <= 2; k++) begin
      p = (k == 1) ? e : m;
      if (p.wr && p.dst != 5'd0) begin
        aN = d.ua && (d.a == p.dst);
        bN = d.ub && (d.b == p.dst);
        if (fwd) begin
          if (k == 1 && p.ld && (aN || (bN && !d.bd))) s = 1'b1;
        end else if (aN || bN) begin
          s = 1'b1;
        end
      end
    end
    return s;
  endfunction

  task automatic runProg(string tagF, string tagN, int expF, int expN);
    int   cnt[2];
    logic st[2];
    logic e;
    for (int m = 0; m < 2; m++) begin
      idS[m] = prog[0]; exS[m] = NOP; memS[m] = NOP; pcI[m] = 1; cnt[m] = 0;
    end
    repeat (3 * progLen + 4) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
        e = refStall(m == 0, idS[m], exS[m], memS[m]);
        vectors++;
        if (pcW[m] !== !e || ifW[m] !== !e || bub[m] !== e) begin
          miscompares++;
          $display("FAIL %s (R8) mode fwd=%0d: pc=%b ifid=%b bubble=%b expected pc=%b ifid=%b bubble=%b",
                   (m == 0) ? tagF : tagN, (m == 0), pcW[m], ifW[m], bub[m], !e, !e, e);
        end
        st[m] = e;
        if (e) cnt[m]++;
      end
      @(posedge clk);
      #1;
      for (int m = 0; m < 2; m++) begin
        memS[m] = exS[m];
        if (st[m]) begin
          exS[m] = NOP;                  // R9: decode held, bubble into execute
        end else begin
          exS[m] = idS[m];
          idS[m] = (pcI[m] < progLen) ? prog[pcI[m]] : NOP;
          pcI[m]++;
        end
      end
    end
    vectors++;
    if (cnt[0] != expF) begin
      miscompares++;
      $display("FAIL %s stall count fwd: actual %0d expected %0d", tagF, cnt[0], expF);
    end
    vectors++;
    if (cnt[1] != expN) begin
      miscompares++;
      $display("FAIL %s stall count nofwd: actual %0d expected %0d", tagN, cnt[1], expN);
    end
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      idS[m] = NOP; exS[m] = NOP; memS[m] = NOP; pcI[m] = 0;
    end
    // R8: idle pipeline lets everything advance
    @(negedge clk);
    vectors++;
    if (pcW !== 2'b11 || ifW !== 2'b11 || bub !== 2'b00) begin
      miscompares++;
      $display("FAIL R8 idle: pc=%b ifid=%b bubble=%b expected 11 11 00", pcW, ifW, bub);
    end
    @(posedge clk); #1;

    // R1 / R4: load then ALU use
    prog[0] = mk(2, 1, 1, 8, 1, 0, 0, 0);
    prog[1] = mk(4, 1, 0, 2, 1, 3, 1, 0);
    progLen = 2; runProg("R1", "R4", 1, 2);

    // R2: load then store of the loaded value
    prog[0] = mk(5, 1, 1, 8, 1, 0, 0, 0);
    prog[1] = mk(0, 0, 0, 6, 1, 5, 1, 1);
    progLen = 2; runProg("R2", "R4", 0, 2);

    // R5: distance three, no stall in either mode
    prog[0] = mk(7, 1, 0, 1, 1, 2, 1, 0);
    prog[1] = NOP; prog[2] = NOP;
    prog[3] = mk(9, 1, 0, 7, 1, 7, 1, 0);
    progLen = 4; runProg("R3", "R5", 0, 0);

    // R5: distance two, one stall without forwarding
    prog[0] = mk(8, 1, 0, 1, 1, 2, 1, 0);
    prog[1] = NOP;
    prog[2] = mk(9, 1, 0, 3, 1, 8, 1, 0);
    progLen = 3; runProg("R3", "R5", 0, 1);

    // R6: register zero and non-writing producers
    prog[0] = mk(0, 1, 1, 8, 1, 0, 0, 0);
    prog[1] = mk(4, 1, 0, 0, 1, 0, 1, 0);
    prog[2] = mk(9, 0, 0, 6, 1, 1, 1, 1);
    prog[3] = mk(4, 1, 0, 9, 1, 9, 1, 0);
    progLen = 4; runProg("R6", "R6", 0, 0);

    // R7: unused source fields carrying the loaded register
    prog[0] = mk(10, 1, 1, 8, 1, 0, 0, 0);
    prog[1] = mk(4, 1, 0, 10, 0, 10, 0, 0);
    progLen = 2; runProg("R7", "R7", 0, 0);

    // R1: store whose base is the loaded register
    prog[0] = mk(11, 1, 1, 8, 1, 0, 0, 0);
    prog[1] = mk(0, 0, 0, 11, 1, 12, 1, 1);
    progLen = 2; runProg("R1", "R4", 1, 2);

    // R1 / R4: both in-flight stages match at once
    prog[0] = mk(3, 1, 1, 20, 1, 0, 0, 0);
    prog[1] = mk(4, 1, 1, 21, 1, 0, 0, 0);
    prog[2] = mk(6, 1, 0, 3, 1, 4, 1, 0);
    progLen = 3; runProg("R1", "R4", 1, 2);

    // R3 / R4: ALU producer directly followed by consumer
    prog[0] = mk(13, 1, 0, 1, 1, 2, 1, 0);
    prog[1] = mk(14, 1, 0, 13, 1, 5, 1, 0);
    progLen = 2; runProg("R3", "R4", 0, 2);

    // R9: load-to-store-data chain without forwarding keeps decode held
    prog[0] = mk(15, 1, 1, 8, 1, 0, 0, 0);
    prog[1] = NOP;
    prog[2] = mk(0, 0, 0, 6, 1, 15, 1, 1);
    progLen = 3; runProg("R3", "R9", 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule